// File: doc/BRIEF.md
# Unlock-Bypass Program Command Decoder

This block watches the write cycles a host issues on a NOR flash bus. It recognises the sequence that puts the device into a fast-programming mode, called bypass mode here. While that mode is active, a single word can be programmed with two writes instead of four. The block turns each completed two-write program into a one-cycle request, which carries the target address and data, toward the array-programming engine. The engine reports that it is occupied through a busy input. Writes that arrive while it is busy are dropped.

Bus writes enter as a valid-qualified stream with no back-pressure. A write counts in the cycle where `wr_valid` is high. Writes are consumed in every cycle, including the ones that are ignored.

The program request stream has no ready signal. Each request is a single-cycle `pgm_valid` pulse that the engine must take in that cycle. The engine throttles further requests by raising `prog_busy`. Writes seen while `prog_busy` is high cannot produce a request, so no request is ever held or queued.

A secure-region input blocks the entry sequence. A two-write exit sequence returns the block to read mode.

Top module: `bypass_cmd_decoder`

## Requirements
- R1: A write of data AAh at address 555h, then 55h at 2AAh, then 20h at any address sets `bypass_mode` at the clock edge that samples the third write.
- R2: In bypass mode, a write of A0h followed by any write produces `pgm_valid` high for exactly one cycle. The pulse appears in the cycle after the edge that samples the second write, with `pgm_addr`/`pgm_data` equal to that write's address and data.
- R3: No request is produced outside bypass mode. In bypass mode, a write that is not a command value leaves the mode set and produces no request.
- R4: In bypass mode, a write of 90h followed by a write of 00h clears `bypass_mode`. After that, A0h has no effect.
- R5: While `secure_en` is high and the block is not in bypass mode, writes are ignored, and bypass mode cannot be entered.
- R6: A write presented with `prog_busy` high, or with `wr_valid` low, is ignored. Any partial sequence is kept as it was.
- R7: A write that does not match the expected unlock step returns the decoder to idle. The full sequence must then start over from the first step.
- R8: In bypass mode, a write that breaks a partial A0h or 90h sequence cancels that sequence, and the block stays in bypass mode.
- R9: An active-low reset clears `bypass_mode`, `pgm_valid` and any partial sequence.
- R10: Command values are compared on `wr_data[7:0]` only. Unlock addresses are compared on `wr_addr[10:0]` only. Higher bits do not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | AW (22) | Write address |
| wr_data | input | DW (16) | Write data |
| secure_en | input | 1 | Secure region active; blocks mode entry |
| prog_busy | input | 1 | Array programming in progress |
| bypass_mode | output | 1 | Bypass mode active |
| pgm_valid | output | 1 | One-cycle program request |
| pgm_addr | output | AW (22) | Program request address |
| pgm_data | output | DW (16) | Program request data |

## Verification
The bench targets the following corner cases:

- **Data of 90h as program data.** A program write whose data is 90h must be taken as data and produce a request. A decoder that re-matched it as a command would swallow that request.
- **Write that breaks a partial sequence.** After 90h, a non-00h write must cancel the partial sequence but keep the mode set. A decoder that fell back to read mode would drop the next program.
- **Busy in the middle of unlock.** A busy write during the unlock sequence must not reset its progress. Likewise, an A0h sent while busy must not arm a program.
- **Secure region, upper bits and reset.** The bench checks that the secure region blocks entry. It checks that upper address and data bits are ignored during decoding. It also asserts reset with a program armed, to confirm that no stale request leaks out afterwards.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  localparam int CMP_AW = 11;
  localparam int CMD_W  = 8;

  localparam logic [CMP_AW-1:0] UNLK_ADDR_A = 11'h555;
  localparam logic [CMP_AW-1:0] UNLK_ADDR_B = 11'h2AA;
  localparam logic [CMD_W-1:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [CMD_W-1:0]  UNLK_DATA_B = 8'h55;
  localparam logic [CMD_W-1:0]  CMD_ENTER   = 8'h20;
  localparam logic [CMD_W-1:0]  CMD_PGM     = 8'hA0;
  localparam logic [CMD_W-1:0]  CMD_EXIT_A  = 8'h90;
  localparam logic [CMD_W-1:0]  CMD_EXIT_B  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_BYP, ST_BPGM, ST_BRST
  } bpd_state_e;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic enter;
    logic pgm;
    logic rst1;
    logic rst2;
  } bpd_match_t;
endpackage

// File: rtl/bpd_cmd_match.sv
module bpd_cmd_match
  import bpd_pkg::*;
(
  input  logic [CMP_AW-1:0] addr_lo,
  input  logic [CMD_W-1:0]  data_lo,
  output bpd_match_t        match
);
  always_comb begin
    match.unl1  = (addr_lo == UNLK_ADDR_A) && (data_lo == UNLK_DATA_A);
    match.unl2  = (addr_lo == UNLK_ADDR_B) && (data_lo == UNLK_DATA_B);
    match.enter = (data_lo == CMD_ENTER);
    match.pgm   = (data_lo == CMD_PGM);
    match.rst1  = (data_lo == CMD_EXIT_A);
    match.rst2  = (data_lo == CMD_EXIT_B);
  end
endmodule

// File: rtl/bpd_seq_fsm.sv
module bpd_seq_fsm
  import bpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       secure_en,
  input  bpd_match_t match,
  output logic       fire,
  output logic       in_bypass
);
  bpd_state_e state_q, state_d;
  logic       take;

  assign in_bypass = (state_q == ST_BYP) || (state_q == ST_BPGM) || (state_q == ST_BRST);
  // secure region freezes the decoder only while outside bypass mode
  assign take = accept && (in_bypass || !secure_en);

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (take) begin
      unique case (state_q)
        ST_IDLE: state_d = match.unl1 ? ST_UNL1 : ST_IDLE;
        ST_UNL1: state_d = match.unl2 ? ST_UNL2 : ST_IDLE;
        ST_UNL2: state_d = match.enter ? ST_BYP : ST_IDLE;
        ST_BYP: begin
          if (match.pgm)       state_d = ST_BPGM;
          else if (match.rst1) state_d = ST_BRST;
          else                 state_d = ST_BYP;
        end
        ST_BPGM: begin
          fire    = 1'b1;
          state_d = ST_BYP;
        end
        ST_BRST: state_d = match.rst2 ? ST_IDLE : ST_BYP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/bpd_pgm_issue.sv
module bpd_pgm_issue #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_addr <= addr;
        req_data <= data;
      end
    end
  end
endmodule

// File: rtl/bypass_cmd_decoder.sv
module bypass_cmd_decoder
  import bpd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          secure_en,
  input  logic          prog_busy,
  output logic          bypass_mode,
  output logic          pgm_valid,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data
);
  bpd_match_t match;
  logic       fire;
  logic       accept;

  assign accept = wr_valid && !prog_busy;

  bpd_cmd_match u_match (
    .addr_lo (wr_addr[CMP_AW-1:0]),
    .data_lo (wr_data[CMD_W-1:0]),
    .match   (match)
  );

  bpd_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .secure_en (secure_en),
    .match     (match),
    .fire      (fire),
    .in_bypass (bypass_mode)
  );

  bpd_pgm_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .addr      (wr_addr),
    .data      (wr_data),
    .req_valid (pgm_valid),
    .req_addr  (pgm_addr),
    .req_data  (pgm_data)
  );
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          secure_en,
  input logic          prog_busy,
  input logic          bypass_mode,
  input logic          pgm_valid,
  input logic [AW-1:0] pgm_addr,
  input logic [DW-1:0] pgm_data
);
  assert_entry_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_mode) |-> $past(wr_valid && wr_data[7:0] == 8'h20));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |=> !pgm_valid);

  assert_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> (pgm_addr == $past(wr_addr) && pgm_data == $past(wr_data)));

  assert_pulse_in_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> bypass_mode);

  assert_exit_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_mode) |-> $past(wr_valid && wr_data[7:0] == 8'h00));

  assert_secure_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_mode && secure_en) |=> !bypass_mode);

  assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid || prog_busy) |=> ($stable(bypass_mode) && !pgm_valid));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!bypass_mode && !pgm_valid));
endmodule

bind bypass_cmd_decoder bpd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .secure_en(secure_en), .prog_busy(prog_busy),
  .bypass_mode(bypass_mode), .pgm_valid(pgm_valid), .pgm_addr(pgm_addr),
  .pgm_data(pgm_data)
);

// File: tb/bypass_cmd_decoder_tb.sv
module bypass_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          secure_en = 1'b0;
  logic          prog_busy = 1'b0;
  logic          bypass_mode, pgm_valid;
  logic [AW-1:0] pgm_addr;
  logic [DW-1:0] pgm_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bypass_cmd_decoder #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .secure_en(secure_en), .prog_busy(prog_busy),
    .bypass_mode(bypass_mode), .pgm_valid(pgm_valid), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        v;
    logic        busy;
    logic        sec;
    logic [21:0] a;
    logic [15:0] d;
    logic        em;
    logic        ep;
    logic [21:0] pa;
    logic [15:0] pd;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    // R1 entry
    '{4'd1,1'b1,1'b0,1'b0,22'h555,16'h00AA,1'b0,1'b0,22'h0,16'h0},
    '{4'd1,1'b1,1'b0,1'b0,22'h2AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd1,1'b1,1'b0,1'b0,22'h123,16'h0020,1'b1,1'b0,22'h0,16'h0},
    // R2 two-write programs
    '{4'd2,1'b1,1'b0,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd2,1'b1,1'b0,1'b0,22'h3456,16'hBEEF,1'b1,1'b1,22'h3456,16'hBEEF},
    '{4'd2,1'b1,1'b0,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd2,1'b1,1'b0,1'b0,22'h3FFFFF,16'h0000,1'b1,1'b1,22'h3FFFFF,16'h0000},
    // R3 non-command write in mode
    '{4'd3,1'b1,1'b0,1'b0,22'h0,16'h0055,1'b1,1'b0,22'h0,16'h0},
    // R2 program data equal to 90h
    '{4'd2,1'b1,1'b0,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd2,1'b1,1'b0,1'b0,22'h10,16'h0090,1'b1,1'b1,22'h10,16'h0090},
    // R8 broken exit keeps mode
    '{4'd4,1'b1,1'b0,1'b0,22'h0,16'h0090,1'b1,1'b0,22'h0,16'h0},
    '{4'd8,1'b1,1'b0,1'b0,22'h0,16'h0012,1'b1,1'b0,22'h0,16'h0},
    '{4'd8,1'b1,1'b0,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd8,1'b1,1'b0,1'b0,22'h77,16'h1234,1'b1,1'b1,22'h77,16'h1234},
    // R4 exit
    '{4'd4,1'b1,1'b0,1'b0,22'h0,16'h0090,1'b1,1'b0,22'h0,16'h0},
    '{4'd4,1'b1,1'b0,1'b0,22'h0,16'h0000,1'b0,1'b0,22'h0,16'h0},
    // R3 no request outside mode
    '{4'd3,1'b1,1'b0,1'b0,22'h0,16'h00A0,1'b0,1'b0,22'h0,16'h0},
    '{4'd3,1'b1,1'b0,1'b0,22'h55,16'h1234,1'b0,1'b0,22'h0,16'h0},
    // R7 unlock mismatch
    '{4'd7,1'b1,1'b0,1'b0,22'h555,16'h00AA,1'b0,1'b0,22'h0,16'h0},
    '{4'd7,1'b1,1'b0,1'b0,22'h2AA,16'h0056,1'b0,1'b0,22'h0,16'h0},
    '{4'd7,1'b1,1'b0,1'b0,22'h2AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd7,1'b1,1'b0,1'b0,22'h0,16'h0020,1'b0,1'b0,22'h0,16'h0},
    // R6 busy keeps partial unlock
    '{4'd6,1'b1,1'b0,1'b0,22'h555,16'h00AA,1'b0,1'b0,22'h0,16'h0},
    '{4'd6,1'b1,1'b1,1'b0,22'h2AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd6,1'b1,1'b0,1'b0,22'h2AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd6,1'b1,1'b0,1'b0,22'h0,16'h0020,1'b1,1'b0,22'h0,16'h0},
    // R6 busy or invalid A0 does not arm
    '{4'd6,1'b1,1'b1,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd6,1'b1,1'b0,1'b0,22'h0,16'h5555,1'b1,1'b0,22'h0,16'h0},
    '{4'd6,1'b0,1'b0,1'b0,22'h0,16'h00A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd6,1'b1,1'b0,1'b0,22'h0,16'h7777,1'b1,1'b0,22'h0,16'h0},
    '{4'd4,1'b1,1'b0,1'b0,22'h0,16'h0090,1'b1,1'b0,22'h0,16'h0},
    '{4'd4,1'b1,1'b0,1'b0,22'h0,16'h0000,1'b0,1'b0,22'h0,16'h0},
    // R5 secure region blocks entry
    '{4'd5,1'b1,1'b0,1'b1,22'h555,16'h00AA,1'b0,1'b0,22'h0,16'h0},
    '{4'd5,1'b1,1'b0,1'b1,22'h2AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd5,1'b1,1'b0,1'b1,22'h0,16'h0020,1'b0,1'b0,22'h0,16'h0},
    '{4'd5,1'b1,1'b0,1'b0,22'h0,16'h0020,1'b0,1'b0,22'h0,16'h0},
    // R10 upper bits ignored
    '{4'd10,1'b1,1'b0,1'b0,22'h3FF555,16'h00AA,1'b0,1'b0,22'h0,16'h0},
    '{4'd10,1'b1,1'b0,1'b0,22'h1002AA,16'h0055,1'b0,1'b0,22'h0,16'h0},
    '{4'd10,1'b1,1'b0,1'b0,22'h0,16'h0020,1'b1,1'b0,22'h0,16'h0},
    '{4'd10,1'b1,1'b0,1'b0,22'h0,16'h12A0,1'b1,1'b0,22'h0,16'h0},
    '{4'd10,1'b1,1'b0,1'b0,22'h5,16'h0A0A,1'b1,1'b1,22'h5,16'h0A0A},
    '{4'd10,1'b1,1'b0,1'b0,22'h0,16'h3390,1'b1,1'b0,22'h0,16'h0},
    '{4'd10,1'b1,1'b0,1'b0,22'h0,16'hFF00,1'b0,1'b0,22'h0,16'h0}
  };

  task automatic chk(input int rq, input string what, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(9, "reset mode", {39'd0, bypass_mode}, 40'd0);
    chk(9, "reset pulse", {39'd0, pgm_valid}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr_valid  = VECS[i].v;
      prog_busy = VECS[i].busy;
      secure_en = VECS[i].sec;
      wr_addr   = VECS[i].a;
      wr_data   = VECS[i].d;
      @(negedge clk);
      chk(int'(VECS[i].rq), $sformatf("vec %0d mode", i), {39'd0, bypass_mode}, {39'd0, VECS[i].em});
      chk(int'(VECS[i].rq), $sformatf("vec %0d pulse", i), {39'd0, pgm_valid}, {39'd0, VECS[i].ep});
      if (VECS[i].ep) begin
        chk(int'(VECS[i].rq), $sformatf("vec %0d addr", i), {18'd0, pgm_addr}, {18'd0, VECS[i].pa});
        chk(int'(VECS[i].rq), $sformatf("vec %0d data", i), {24'd0, pgm_data}, {24'd0, VECS[i].pd});
      end
    end
    wr_valid  = 1'b0;
    prog_busy = 1'b0;
    secure_en = 1'b0;

    // R9: reset with a program armed leaves no stale request
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h0, 16'h0020);
    chk(1, "re-entry mode", {39'd0, bypass_mode}, 40'd1);
    wr(22'h0, 16'h00A0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(9, "mode in reset", {39'd0, bypass_mode}, 40'd0);
    rst_n = 1'b1;
    wr(22'h44, 16'h1234);
    chk(9, "no stale request", {39'd0, pgm_valid}, 40'd0);
    chk(9, "mode after reset", {39'd0, bypass_mode}, 40'd0);
    @(negedge clk);
    chk(9, "no late request", {39'd0, pgm_valid}, 40'd0);

    report();
    $finish;
  end
endmodule